// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Core

This block is the digital core of a small byte-wide nonvolatile memory reached over SPI. The array is 8 bits wide and between 128 and 2048 bytes deep, set by a parameter. A system clock oversamples the serial pins (chip select, serial clock, data in, pause and write-protect). Bus modes 0 and 3 are both accepted. Every transfer starts with a one-byte opcode. Reads and page writes then take a two-byte address, and the status register can be read or written.

Incoming write data goes into a page buffer. The page holds 16 bytes for arrays up to 512 bytes and 32 bytes for larger arrays. When chip select rises on a byte boundary, a self-timed write cycle begins. Its length is a parameterized count of clock cycles. During that cycle the buffer is copied into the array, skipping any byte that falls in a protected range. Two status bits select block protection of the upper quarter, the upper half or the whole array. A low level on the write-protect pin freezes those bits. Driving the pause input low stops a transfer without losing its place.

Top module: `eeprom_spi_slave`

## Requirements
- R1: After reset the status byte reads 0x00 and the serial output enable is low.
- R2: READ (0x03) takes two address bytes, and address bits above the array size are ignored. It returns bytes MSB first: each bit changes after a falling SCK edge and is valid for the next rising edge. The address increments after each byte and wraps from the last location to 0.
- R3: The status byte is {4'b0, prot[1:0], wen, busy}. The wen bit is bit 1 and the busy bit is bit 0. WREN (0x06) sets wen, WRDI (0x04) clears it, and RDSR (0x05) returns the status byte repeatedly for as long as clocking continues.
- R4: WRITE (0x02) and WRSR (0x01) are ignored when wen is 0.
- R5: Write data that runs past the end of a page wraps to the start of the same page. The page is 16 bytes for arrays up to 512 bytes and 32 bytes otherwise.
- R6: A WRITE whose chip select rises off a byte boundary is aborted. No location changes, no write cycle starts, and wen stays set.
- R7: A committed WRITE or WRSR sets busy for WRITE_CYCLES clocks and clears wen. While busy is set, every opcode except RDSR is ignored.
- R8: WRSR data bits [3:2] set prot. The value 01 guards the upper quarter, 10 the upper half and 11 the whole array. Guarded bytes keep their contents when written.
- R9: While wp_n is low, WRSR is ignored, so prot cannot change.
- R10: While hold_n is low, SCK edges are ignored and the output enable is low. When hold_n returns high, the transfer continues from the same bit.
- R11: The output enable is low whenever cs_n is high.
- R12: Bus modes 0 (SCK idles low) and 3 (SCK idles high) give the same results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in, sampled on rising SCK |
| hold_n | input | 1 | Active-low transfer pause |
| wp_n | input | 1 | Active-low status write protect |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for so; a pad drives high impedance when it is low |

## Verification
Each pin passes through a two-flop synchronizer, and one more register stage detects the edge. An output bit therefore appears three to four clocks after a falling SCK edge. The bench holds each SCK phase for eight clocks and samples so just before the rising edge, well after that bit settles. The write cycle starts about three clocks after chip select rises, so the first status read issued after a write must show busy. The bench sizes the write time so that two status reads and an ignored WREN all fit inside it. The bench waits for busy to clear by polling the status register, never by counting a fixed delay. The output-enable checks during a pause and after chip select rises are taken a full SCK phase after the pin change, which is longer than the synchronizer plus output register delay.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WREN = 8'h06;

  typedef enum logic [3:0] {
    ST_OPC,
    ST_AHI,
    ST_ALO,
    ST_RDAT,
    ST_WDAT,
    ST_STAT,
    ST_SREG,
    ST_SDONE,
    ST_IGN
  } xfer_st_t;

  function automatic int page_bytes(input int depth);
    return (depth >= 1024) ? 32 : 16;
  endfunction

endpackage

// File: rtl/eeprom_pin_sync.sv
module eeprom_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  input  logic wp_n,
  output logic cs_act,
  output logic cs_rise,
  output logic sck_rise,
  output logic sck_fall,
  output logic si_s,
  output logic hold_s,
  output logic wp_s
);
  logic [STAGES-1:0] sck_m, cs_m, si_m, hold_m, wp_m;
  logic sck_d, cs_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_m  <= '0;
      si_m   <= '0;
      cs_m   <= '1;
      hold_m <= '1;
      wp_m   <= '1;
      sck_d  <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sck_m  <= {sck_m[STAGES-2:0], sck};
      si_m   <= {si_m[STAGES-2:0], si};
      cs_m   <= {cs_m[STAGES-2:0], cs_n};
      hold_m <= {hold_m[STAGES-2:0], hold_n};
      wp_m   <= {wp_m[STAGES-2:0], wp_n};
      sck_d  <= sck_m[STAGES-1];
      cs_d   <= cs_m[STAGES-1];
    end
  end

  assign cs_act   = ~cs_m[STAGES-1];
  assign cs_rise  = cs_m[STAGES-1] & ~cs_d;
  assign hold_s   = hold_m[STAGES-1];
  assign wp_s     = wp_m[STAGES-1];
  assign si_s     = si_m[STAGES-1];
  assign sck_rise = sck_m[STAGES-1] & ~sck_d & cs_act & hold_s;
  assign sck_fall = ~sck_m[STAGES-1] & sck_d & cs_act & hold_s;

endmodule

// File: rtl/eeprom_wtimer.sv
module eeprom_wtimer #(
  parameter int CYCLES = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (start) cnt <= CW'(CYCLES);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
  parameter int DEPTH = 2048,
  parameter int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/eeprom_spi_slave.sv
module eeprom_spi_slave
  import eeprom_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int WRITE_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  input  logic wp_n,
  output logic so,
  output logic so_oe
);
  localparam int AW = $clog2(DEPTH);
  localparam int PAGE = page_bytes(DEPTH);
  localparam int PW = $clog2(PAGE);

  logic cs_act, cs_rise, sck_rise, sck_fall, si_s, hold_s, wp_s;
  logic busy, tmr_go, commit_go, cact;
  xfer_st_t st;
  logic [2:0] bcnt;
  logic [6:0] sh;
  logic [7:0] inb, addr_hi, tx, rdata, stat_b, ld;
  logic [15:0] full_a;
  logic rd_mode, wel, got;
  logic [1:0] bp, bp_new;
  logic [AW-1:0] rd_ptr;
  logic [AW-PW-1:0] pg_hi;
  logic [PW-1:0] wptr, cidx;
  logic [PAGE-1:0] pvalid;
  logic [7:0] pbuf [PAGE];
  logic byte_done, wr_byte, mem_we;
  logic [AW-1:0] mem_waddr;

  eeprom_pin_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n), .wp_n(wp_n),
    .cs_act(cs_act), .cs_rise(cs_rise), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .si_s(si_s), .hold_s(hold_s), .wp_s(wp_s)
  );

  eeprom_wtimer #(.CYCLES(WRITE_CYCLES)) u_tmr (
    .clk(clk), .rst(rst), .start(tmr_go), .busy(busy)
  );

  eeprom_array #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(pbuf[cidx]),
    .raddr(rd_ptr), .rdata(rdata)
  );

  function automatic logic guarded(input logic [1:0] b, input logic [AW-1:0] a);
    case (b)
      2'b00:   return 1'b0;
      2'b01:   return a[AW-1] & a[AW-2];
      2'b10:   return a[AW-1];
      default: return 1'b1;
    endcase
  endfunction

  assign inb       = {sh, si_s};
  assign full_a    = {addr_hi, inb};
  assign byte_done = sck_rise && (bcnt == 3'd7);
  assign wr_byte   = byte_done && (st == ST_WDAT);
  assign stat_b    = {4'b0000, bp, wel, busy};
  assign ld        = (st == ST_STAT) ? stat_b : rdata;
  assign mem_waddr = {pg_hi, cidx};
  assign mem_we    = cact && pvalid[cidx] && !guarded(bp, mem_waddr);

  // transfer control and status register
  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_OPC; bcnt <= '0; sh <= '0; addr_hi <= '0; rd_mode <= 1'b0;
      wel <= 1'b0; bp <= 2'b00; bp_new <= 2'b00; got <= 1'b0;
      wptr <= '0; pg_hi <= '0; pvalid <= '0; commit_go <= 1'b0; tmr_go <= 1'b0;
    end else begin
      commit_go <= 1'b0;
      tmr_go <= 1'b0;
      if (cs_rise) begin
        if (st == ST_WDAT && bcnt == 3'd0 && got) begin
          commit_go <= 1'b1; tmr_go <= 1'b1; wel <= 1'b0;
        end
        if (st == ST_SDONE && bcnt == 3'd0 && wp_s) begin
          bp <= bp_new; tmr_go <= 1'b1; wel <= 1'b0;
        end
        st <= ST_OPC; bcnt <= '0;
      end else if (!cs_act) begin
        st <= ST_OPC; bcnt <= '0;
      end else if (sck_rise) begin
        sh <= inb[6:0];
        bcnt <= bcnt + 3'd1;
        if (bcnt == 3'd7) begin
          case (st)
            ST_OPC: begin
              if (busy && inb != OP_RDSR) st <= ST_IGN;
              else begin
                case (inb)
                  OP_READ:  begin st <= ST_AHI; rd_mode <= 1'b1; end
                  OP_WRITE: begin st <= wel ? ST_AHI : ST_IGN; rd_mode <= 1'b0; end
                  OP_RDSR:  st <= ST_STAT;
                  OP_WRSR:  st <= wel ? ST_SREG : ST_IGN;
                  OP_WREN:  begin wel <= 1'b1; st <= ST_IGN; end
                  OP_WRDI:  begin wel <= 1'b0; st <= ST_IGN; end
                  default:  st <= ST_IGN;
                endcase
              end
            end
            ST_AHI: begin addr_hi <= inb; st <= ST_ALO; end
            ST_ALO: begin
              if (rd_mode) st <= ST_RDAT;
              else begin
                st <= ST_WDAT;
                pg_hi <= full_a[AW-1:PW];
                wptr <= full_a[PW-1:0];
                pvalid <= '0;
                got <= 1'b0;
              end
            end
            ST_WDAT: begin pvalid[wptr] <= 1'b1; wptr <= wptr + 1'b1; got <= 1'b1; end
            ST_SREG: begin bp_new <= inb[3:2]; st <= ST_SDONE; end
            default: ;
          endcase
        end
      end
    end
  end

  // page buffer storage
  always_ff @(posedge clk) begin
    if (wr_byte) pbuf[wptr] <= inb;
  end

  // commit walk over the page during the write cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      cact <= 1'b0; cidx <= '0;
    end else if (commit_go) begin
      cact <= 1'b1; cidx <= '0;
    end else if (cact) begin
      cidx <= cidx + 1'b1;
      if (cidx == PW'(PAGE - 1)) cact <= 1'b0;
    end
  end

  // read pointer
  always_ff @(posedge clk) begin
    if (rst) rd_ptr <= '0;
    else if (byte_done && st == ST_ALO && rd_mode) rd_ptr <= full_a[AW-1:0];
    else if (sck_fall && bcnt == 3'd0 && st == ST_RDAT) rd_ptr <= rd_ptr + 1'b1;
  end

  // serial output
  always_ff @(posedge clk) begin
    if (rst) begin
      tx <= '0; so <= 1'b0; so_oe <= 1'b0;
    end else begin
      so_oe <= cs_act && hold_s && (st == ST_RDAT || st == ST_STAT);
      if (sck_fall) begin
        if (bcnt == 3'd0) begin
          so <= ld[7]; tx <= {ld[6:0], 1'b0};
        end else begin
          so <= tx[7]; tx <= {tx[6:0], 1'b0};
        end
      end
    end
  end

endmodule

// File: rtl/eeprom_spi_slave_chk.sv
module eeprom_spi_slave_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs_act,
  input logic       hold_s,
  input logic       wp_s,
  input logic       so_oe,
  input logic [1:0] bp,
  input logic [2:0] bcnt,
  input logic       mem_we,
  input logic       busy,
  input logic       wel
);
  p_so_off_cs_r11: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !so_oe);
  p_so_off_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !hold_s |=> !so_oe);
  p_hold_keeps_count_r10: assert property (@(posedge clk) disable iff (rst)
    (cs_act && !hold_s) |=> $stable(bcnt));
  p_wp_locks_prot_r9: assert property (@(posedge clk) disable iff (rst)
    !wp_s |=> $stable(bp));
  p_write_in_busy_r7: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);
  p_wen_cleared_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !wel);
endmodule

bind eeprom_spi_slave eeprom_spi_slave_chk u_chk (
  .clk(clk), .rst(rst), .cs_act(cs_act), .hold_s(hold_s), .wp_s(wp_s),
  .so_oe(so_oe), .bp(bp), .bcnt(bcnt), .mem_we(mem_we), .busy(busy), .wel(wel)
);

// File: tb/eeprom_spi_slave_bench.sv
module eeprom_spi_slave_bench;
  localparam int HP = 80;

  logic clk = 1'b0, rst = 1'b1;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
  wire so, so_oe;

  always #5 clk = ~clk;

  eeprom_spi_slave #(.DEPTH(2048), .WRITE_CYCLES(2000)) u_eeprom_spi_slave (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si),
    .hold_n(hold_n), .wp_n(wp_n), .so(so), .so_oe(so_oe)
  );

  int total = 0, bad = 0;
  bit mode3 = 1'b0;
  logic [7:0] exp_v[$];
  string exp_t[$];
  logic [7:0] obs_q[$];
  event obs_ev;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic expect_b(input logic [7:0] v, input string t);
    exp_v.push_back(v);
    exp_t.push_back(t);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(obs_ev);
      while (obs_q.size() > 0) begin
        logic [7:0] v, e;
        string t;
        v = obs_q.pop_front();
        if (exp_v.size() == 0) chk(1'b0, "unexpected byte", v, 0);
        else begin
          e = exp_v.pop_front();
          t = exp_t.pop_front();
          chk(v === e, t, v, e);
        end
      end
    end
  end

  task automatic observe(input logic [7:0] v);
    obs_q.push_back(v);
    ->obs_ev;
  endtask

  task automatic bit_x(input logic b, output logic r);
    sck = 1'b0; si = b; #HP;
    r = so;
    sck = 1'b1; #HP;
  endtask

  task automatic byte_x(input logic [7:0] t, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) bit_x(t[i], r[i]);
  endtask

  task automatic cs_lo();
    sck = mode3; #HP;
    cs_n = 1'b0; #HP;
  endtask

  task automatic cs_hi();
    if (!mode3) sck = 1'b0;
    #HP; cs_n = 1'b1; #HP; #HP;
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] r;
    cs_lo(); byte_x(op, r); cs_hi();
  endtask

  task automatic rdsr_raw(output logic [7:0] v);
    logic [7:0] r;
    cs_lo(); byte_x(8'h05, r); byte_x(8'h00, v); cs_hi();
  endtask

  task automatic rdsr_sb();
    logic [7:0] v;
    rdsr_raw(v);
    observe(v);
  endtask

  task automatic wait_ready();
    logic [7:0] v;
    for (int i = 0; i < 30; i++) begin
      rdsr_raw(v);
      if (!v[0]) return;
    end
    chk(1'b0, "R7 busy never cleared", v, 0);
  endtask

  task automatic wrsr(input logic [7:0] d);
    logic [7:0] r;
    cs_lo(); byte_x(8'h01, r); byte_x(d, r); cs_hi();
  endtask

  task automatic wr(input logic [15:0] a, input int n, input logic [31:0] d);
    logic [7:0] r;
    cs_lo(); byte_x(8'h02, r); byte_x(a[15:8], r); byte_x(a[7:0], r);
    for (int i = 0; i < n; i++) byte_x(d[8*(n-1-i) +: 8], r);
    cs_hi();
  endtask

  task automatic rd(input logic [15:0] a, input int n);
    logic [7:0] r, v;
    cs_lo(); byte_x(8'h03, r); byte_x(a[15:8], r); byte_x(a[7:0], r);
    for (int i = 0; i < n; i++) begin
      byte_x(8'h00, v);
      observe(v);
    end
    cs_hi();
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #1500000;
    chk(1'b0, "watchdog expired", 0, 1);
    finish_up();
  end

  initial begin
    logic [7:0] r, v;
    #100 rst = 1'b0;
    #40;
    chk(so_oe === 1'b0, "R1 so_oe after reset", so_oe, 0);
    expect_b(8'h00, "R1 status after reset"); rdsr_sb();

    // R4: write without enable is ignored
    wr(16'h0010, 1, 32'hAA);
    expect_b(8'h00, "R4 no busy without wen"); rdsr_sb();
    expect_b(8'hFF, "R4 location unchanged"); rd(16'h0010, 1);

    // R3: enable latch set and clear
    cmd1(8'h06);
    expect_b(8'h02, "R3 wen set"); rdsr_sb();
    cmd1(8'h04);
    expect_b(8'h00, "R3 wen cleared"); rdsr_sb();

    // R5 page wrap, R7 busy window
    cmd1(8'h06);
    wr(16'h003E, 3, 32'h00112233);
    expect_b(8'h01, "R7 busy set wen cleared"); rdsr_sb();
    cmd1(8'h06);
    expect_b(8'h01, "R7 WREN ignored while busy"); rdsr_sb();
    wait_ready();
    expect_b(8'h00, "R7 idle after write cycle"); rdsr_sb();
    expect_b(8'h33, "R5 wrapped byte at page start"); rd(16'h0020, 1);
    expect_b(8'h11, "R2 read first");
    expect_b(8'h22, "R2 read increment");
    expect_b(8'hFF, "R5 next page untouched");
    rd(16'h003E, 3);
    expect_b(8'h11, "R2 upper address bits ignored"); rd(16'hF83E, 1);

    // R2 wrap at end of array
    cmd1(8'h06); wr(16'h07FF, 1, 32'h5A); wait_ready();
    expect_b(8'h5A, "R2 last location");
    expect_b(8'hFF, "R2 wrap to zero");
    rd(16'h07FF, 2);

    // R6 abort off byte boundary
    cmd1(8'h06);
    cs_lo(); byte_x(8'h02, r); byte_x(8'h01, r); byte_x(8'h00, r); byte_x(8'h77, r);
    for (int i = 0; i < 3; i++) bit_x(1'b1, r[0]);
    cs_hi();
    expect_b(8'h02, "R6 no busy, wen kept"); rdsr_sb();
    expect_b(8'hFF, "R6 nothing written"); rd(16'h0100, 1);
    cmd1(8'h04);

    // R8 block protection
    cmd1(8'h06); wrsr(8'h04); wait_ready();
    expect_b(8'h04, "R8 prot quarter"); rdsr_sb();
    cmd1(8'h06); wr(16'h0600, 1, 32'hC3); wait_ready();
    cmd1(8'h06); wr(16'h05FF, 1, 32'h3C); wait_ready();
    expect_b(8'h3C, "R8 below quarter written");
    expect_b(8'hFF, "R8 quarter guarded");
    rd(16'h05FF, 2);
    cmd1(8'h06); wrsr(8'h08); wait_ready();
    cmd1(8'h06); wr(16'h0400, 1, 32'h81); wait_ready();
    expect_b(8'hFF, "R8 half guarded"); rd(16'h0400, 1);
    cmd1(8'h06); wrsr(8'h0C); wait_ready();
    cmd1(8'h06); wr(16'h0000, 1, 32'h12); wait_ready();
    expect_b(8'hFF, "R8 whole array guarded"); rd(16'h0000, 1);

    // R9 write protect pin
    wp_n = 1'b0;
    cmd1(8'h06); wrsr(8'h00);
    expect_b(8'h0E, "R9 prot frozen by wp_n"); rdsr_sb();
    wp_n = 1'b1;
    wrsr(8'h00); wait_ready();
    expect_b(8'h00, "R9 prot cleared with wp_n high"); rdsr_sb();

    // R10 pause in mid byte
    cs_lo(); byte_x(8'h03, r); byte_x(8'h00, r); byte_x(8'h3E, r);
    for (int i = 7; i >= 4; i--) bit_x(1'b0, v[i]);
    hold_n = 1'b0; #HP;
    chk(so_oe === 1'b0, "R10 so_oe low during pause", so_oe, 0);
    for (int i = 0; i < 3; i++) begin
      sck = 1'b0; si = 1'b1; #HP; sck = 1'b1; #HP;
    end
    hold_n = 1'b1; #HP;
    chk(so_oe === 1'b1, "R10 so_oe back after pause", so_oe, 1);
    for (int i = 3; i >= 0; i--) bit_x(1'b0, v[i]);
    expect_b(8'h11, "R10 byte intact across pause"); observe(v);
    byte_x(8'h00, v);
    expect_b(8'h22, "R10 next byte after pause"); observe(v);
    cs_hi();
    chk(so_oe === 1'b0, "R11 so_oe low with cs_n high", so_oe, 0);

    // R12 mode 3
    mode3 = 1'b1; sck = 1'b1; #HP;
    expect_b(8'h33, "R12 mode 3 read"); rd(16'h0020, 1);
    cmd1(8'h06); wr(16'h0080, 1, 32'h99); wait_ready();
    expect_b(8'h99, "R12 mode 3 write readback"); rd(16'h0080, 1);
    mode3 = 1'b0; sck = 1'b0; #HP;

    #1000;
    chk(exp_v.size() == 0, "scoreboard leftover items", exp_v.size(), 0);
    finish_up();
  end

endmodule